// File: doc/BRIEF.md
# Supervisor Operating Mode Sequencer

This block follows the operating mode of a supply-and-supervision companion chip. It takes digital event pulses from the outside world and decoded register writes from the serial host port, and from them decides the chip's current mode: reset, normal-request, normal, standby, sleep or stop. After a power-up, and after a wake from sleep, it always passes through reset mode for a fixed number of cycles and then waits in normal-request mode. It only moves on to normal mode when the host writes the timer register.

The block also keeps a battery-fail flag and a debug flag. The battery-fail flag is raised by every power-up and cleared by a host read of the status register. The debug flag turns off the software watchdog. To set it, the host must write the value 0000 to the mode-control register while the device is in normal mode, after the timer write and before the status read. Once the flag is set, only a new power-up clears it. A maskable low-battery interrupt is raised only in normal and standby modes.

The sources that can wake the device from sleep or stop are a CAN wake pulse, which cannot be masked, and a rising edge on the asynchronous chip-select line. The chip-select line passes through a two-flop synchronizer and an edge detector before it is used.

Top module: `sbc_mode_seq`

## Requirements
- R1: When `rst_n` is low, or on a clock edge where `por_pulse` is high, the block takes the power-up state. In that state `mode` is 0 (reset), `batfail` is 1, `debug_on` is 0 and the interrupt enable is 0. `mode` stays 0 for RESET_LEN cycles (default 4) and then becomes 1 (normal-request).
- R2: A write to address 3'b010 (timer register) while `mode` is 1 makes `mode` 2 (normal) on the next cycle.
- R3: A write to address 3'b000 (mode-control register) while `mode` is 2 or 3 changes the mode on the next cycle. Data 0001 selects standby (3), data 0010 selects stop (5), and data 0011 selects sleep (4). In standby, data 0100 selects normal (2).
- R4: A `can_wake` pulse in sleep (4) sets `mode` to 0 on the next cycle, and the normal reset sequence follows. A `can_wake` pulse in stop (5) sets `mode` to 2. This wake source cannot be masked.
- R5: A low-to-high transition of `cs_n` while the device is in sleep or stop acts as a wake with the same effect as R4. The mode changes on the third rising clock edge after `cs_n` goes high. A falling edge does not wake the device.
- R6: A mode-control write of data 0000 while `mode` is 2 sets `debug_on` on the next cycle and leaves `mode` unchanged. This happens only if `batfail` is set and a timer write has occurred since the last power-up. In every other case the write has no effect on `debug_on`.
- R7: A `rd_status` pulse clears `batfail` on the next cycle. If `por_pulse` is high in the same cycle, the power-up takes priority.
- R8: Once `debug_on` is set, it stays set through standby, stop, sleep and wake-up. Only a power-up (R1) clears it.
- R9: `irq` equals `vbat_low` AND the interrupt enable AND (`mode` is 2 or 3). The interrupt enable is bit 0 of a write to address 3'b101.
- R10: `lowbat_flag` is a registered copy of `vbat_low`, with one cycle of delay.
- R11: When `por_pulse` and a wake arrive in the same cycle, the power-up takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; has the same effect as a power-up |
| por_pulse | input | 1 | Power-up event, one cycle long |
| can_wake | input | 1 | CAN wake event, one cycle long |
| cs_n | input | 1 | Asynchronous serial chip-select line |
| vbat_low | input | 1 | Low-battery comparator result |
| wr_stb | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 4 | Data of the write |
| rd_status | input | 1 | Status register read strobe |
| mode | output | 3 | Current mode: 0 reset, 1 normal-request, 2 normal, 3 standby, 4 sleep, 5 stop |
| batfail | output | 1 | Battery-fail flag |
| debug_on | output | 1 | Watchdog-disable (debug) active |
| lowbat_flag | output | 1 | Registered low-battery status |
| irq | output | 1 | Low-battery interrupt |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a debug-arming write and a status read. The bench drives `wr_stb` and `rd_status` together. It then checks that the arming still succeeds, because the write sees the battery-fail flag before the read clears it, and that the flag is clear afterwards. The second pair is a power-up and a CAN wake, driven together while the device is in sleep. The bench checks that the device enters the power-up state with debug cleared, and that the reset sequence then runs for its full length.

// File: rtl/sbc_mode_seq.sv
module sbc_mode_seq #(
  parameter int RESET_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_pulse,
  input  logic       can_wake,
  input  logic       cs_n,
  input  logic       vbat_low,
  input  logic       wr_stb,
  input  logic [2:0] wr_addr,
  input  logic [3:0] wr_data,
  input  logic       rd_status,
  output logic [2:0] mode,
  output logic       batfail,
  output logic       debug_on,
  output logic       lowbat_flag,
  output logic       irq
);
  localparam int CNT_W = $clog2(RESET_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESET_LEN - 1);
  localparam logic [2:0] M_RST = 3'd0, M_NREQ = 3'd1, M_NORM = 3'd2,
                         M_STBY = 3'd3, M_SLEEP = 3'd4, M_STOP = 3'd5;
  localparam logic [2:0] A_MCR = 3'd0, A_TIM = 3'd2, A_IEN = 3'd5;

  logic cs_meta, cs_sync, cs_prev;
  logic [CNT_W-1:0] cnt;
  logic tim_seen, irq_en;
  logic [2:0] mode_nxt;

  wire cs_rise = cs_sync & ~cs_prev;
  wire wake    = can_wake | cs_rise;
  wire wr_mcr  = wr_stb && wr_addr == A_MCR;
  wire wr_tim  = wr_stb && wr_addr == A_TIM;
  wire wr_ien  = wr_stb && wr_addr == A_IEN;
  wire arm     = wr_mcr && wr_data == 4'b0000 && mode == M_NORM && batfail && tim_seen;

  assign irq = vbat_low & irq_en & (mode == M_NORM || mode == M_STBY);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {cs_meta, cs_sync, cs_prev} <= 3'b111;
    else        {cs_meta, cs_sync, cs_prev} <= {cs_n, cs_meta, cs_sync};

  always_comb begin
    mode_nxt = mode;
    case (mode)
      M_RST:   if (cnt == CNT_LAST) mode_nxt = M_NREQ;
      M_NREQ:  if (wr_tim) mode_nxt = M_NORM;
      M_NORM, M_STBY:
        if (wr_mcr)
          case (wr_data)
            4'b0001: mode_nxt = M_STBY;
            4'b0010: mode_nxt = M_STOP;
            4'b0011: mode_nxt = M_SLEEP;
            4'b0100: if (mode == M_STBY) mode_nxt = M_NORM;
            default: ;
          endcase
      M_SLEEP: if (wake) mode_nxt = M_RST;
      M_STOP:  if (wake) mode_nxt = M_NORM;
      default: mode_nxt = M_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= M_RST; cnt <= '0; batfail <= 1'b1; debug_on <= 1'b0;
      tim_seen <= 1'b0; irq_en <= 1'b0; lowbat_flag <= 1'b0;
    end else begin
      lowbat_flag <= vbat_low;
      if (por_pulse) begin
        mode <= M_RST; cnt <= '0; batfail <= 1'b1; debug_on <= 1'b0;
        tim_seen <= 1'b0; irq_en <= 1'b0;
      end else begin
        mode <= mode_nxt;
        cnt  <= (mode == M_RST && mode_nxt == M_RST) ? cnt + 1'b1 : '0;
        if (rd_status) batfail <= 1'b0;
        if (arm) debug_on <= 1'b1;
        if (wr_tim) tim_seen <= 1'b1;
        if (wr_ien) irq_en <= wr_data[0];
      end
    end
endmodule

// File: rtl/sbc_mode_seq_chk.sv
module sbc_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_pulse,
  input logic       can_wake,
  input logic       wr_stb,
  input logic [2:0] wr_addr,
  input logic       rd_status,
  input logic [2:0] mode,
  input logic       batfail,
  input logic       debug_on,
  input logic       irq
);
  p_por_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |=> (mode == 3'd0 && batfail && !debug_on));
  p_tim_to_normal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == 3'd2 && mode == 3'd1 && !por_pulse) |=> mode == 3'd2);
  p_can_wake_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (can_wake && mode == 3'd4 && !por_pulse) |=> mode == 3'd0);
  p_debug_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(debug_on) |-> $past(batfail));
  p_status_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !por_pulse) |=> !batfail);
  p_debug_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_on && !por_pulse) |=> debug_on);
  p_irq_modes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mode == 3'd2 || mode == 3'd3));
endmodule

bind sbc_mode_seq sbc_mode_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .can_wake(can_wake),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .rd_status(rd_status),
  .mode(mode), .batfail(batfail), .debug_on(debug_on), .irq(irq)
);

// File: tb/sbc_mode_seq_tb.sv
module sbc_mode_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic por_pulse = 0, can_wake = 0, cs_n = 1, vbat_low = 0;
  logic wr_stb = 0, rd_status = 0;
  logic [2:0] wr_addr = 0;
  logic [3:0] wr_data = 0;
  logic [2:0] mode;
  logic batfail, debug_on, lowbat_flag, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sbc_mode_seq dut_i (
    .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .can_wake(can_wake),
    .cs_n(cs_n), .vbat_low(vbat_low), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_status(rd_status), .mode(mode), .batfail(batfail),
    .debug_on(debug_on), .lowbat_flag(lowbat_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    wr_stb = 1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_stb = 0;
  endtask

  task automatic power_up_to_normal();
    por_pulse = 1; cyc(1); por_pulse = 0;
    chk("R1 por mode", mode, 0);
    chk("R1 por batfail", batfail, 1);
    chk("R8 por clears debug", debug_on, 0);
    cyc(3); chk("R1 still reset", mode, 0);
    cyc(1); chk("R1 nreq", mode, 1);
    wr(3'd2, 4'd0); chk("R2 normal", mode, 2);
  endtask

  task automatic t_reset();
    chk("R1 reset mode", mode, 0);
    chk("R1 reset batfail", batfail, 1);
    chk("R1 reset debug", debug_on, 0);
    chk("R1 reset irq", irq, 0);
    cyc(3); chk("R1 reset hold", mode, 0);
    cyc(1); chk("R1 to nreq", mode, 1);
    wr(3'd0, 4'd0); chk("R6 no arm in nreq", debug_on, 0);
    chk("R6 nreq mode kept", mode, 1);
    wr(3'd2, 4'd0); chk("R2 tim to normal", mode, 2);
  endtask

  task automatic t_debug_and_modes();
    wr(3'd0, 4'd0);
    chk("R6 armed", debug_on, 1); chk("R6 mode kept", mode, 2);
    wr(3'd0, 4'd1); chk("R3 standby", mode, 3); chk("R8 debug in standby", debug_on, 1);
    wr(3'd0, 4'd4); chk("R3 back normal", mode, 2);
    wr(3'd0, 4'd2); chk("R3 stop", mode, 5);
    can_wake = 1; cyc(1); can_wake = 0;
    chk("R4 stop wake normal", mode, 2);
    wr(3'd0, 4'd3); chk("R3 sleep", mode, 4);
    can_wake = 1; cyc(1); can_wake = 0;
    chk("R4 sleep wake reset", mode, 0);
    cyc(4); chk("R4 then nreq", mode, 1);
    chk("R8 debug after wake", debug_on, 1);
  endtask

  task automatic t_batfail_clear();
    power_up_to_normal();
    rd_status = 1; cyc(1); rd_status = 0;
    chk("R7 batfail cleared", batfail, 0);
    wr(3'd0, 4'd0); chk("R6 rejected no batfail", debug_on, 0);
  endtask

  task automatic t_cs_wake();
    wr(3'd0, 4'd3); chk("R3 sleep for cs", mode, 4);
    cs_n = 0; cyc(3); chk("R5 falling no wake", mode, 4);
    cs_n = 1; cyc(2); chk("R5 not yet", mode, 4);
    cyc(1); chk("R5 cs wake", mode, 0);
    cyc(4); wr(3'd2, 4'd0);
    wr(3'd0, 4'd2); chk("R3 stop for cs", mode, 5);
    cs_n = 0; cyc(3); cs_n = 1; cyc(3);
    chk("R5 cs wake stop", mode, 2);
  endtask

  task automatic t_irq();
    vbat_low = 1; cyc(1);
    chk("R10 lowbat flag", lowbat_flag, 1);
    chk("R9 masked", irq, 0);
    wr(3'd5, 4'd1); chk("R9 irq normal", irq, 1);
    wr(3'd0, 4'd1); chk("R9 irq standby", irq, 1);
    wr(3'd0, 4'd2); chk("R9 no irq stop", irq, 0);
    can_wake = 1; cyc(1); can_wake = 0;
    wr(3'd5, 4'd0); chk("R9 disabled", irq, 0);
    vbat_low = 0; cyc(1); chk("R10 flag low", lowbat_flag, 0);
  endtask

  task automatic t_collisions();
    por_pulse = 1; cyc(1); por_pulse = 0;
    cyc(4); wr(3'd2, 4'd0);
    wr_stb = 1; wr_addr = 3'd0; wr_data = 4'd0; rd_status = 1;
    cyc(1); wr_stb = 0; rd_status = 0;
    chk("R6 arm with read", debug_on, 1);
    chk("R7 read cleared", batfail, 0);
    wr(3'd0, 4'd3); chk("R3 sleep", mode, 4);
    por_pulse = 1; can_wake = 1; cyc(1); por_pulse = 0; can_wake = 0;
    chk("R11 por wins mode", mode, 0);
    chk("R11 por wins debug", debug_on, 0);
    chk("R11 por wins batfail", batfail, 1);
    cyc(3); chk("R11 full reset", mode, 0);
    cyc(1); chk("R11 nreq", mode, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_debug_and_modes();
    t_batfail_clear();
    t_cs_wake();
    t_irq();
    t_collisions();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog: actual 1 expected 0"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule